// File: doc/BRIEF.md
# Two-Register Accumulator-Style Micro Core

This block is a very small processor core. It has two 8-bit general registers, a 4-bit program counter and a single sixteen-word, 8-bit memory that holds both code and data. Each instruction takes two clock cycles. In the first cycle the word at the program counter is copied into an instruction register. In the second cycle the core carries out that instruction. The instruction set covers five operations: increment a register, decrement a register, branch when register 0 is zero, store a register to memory, and load a register from memory.

The arithmetic path is one adder/subtractor with the constant one as its second operand, followed by a pass-through path that serves memory loads. Memory is filled through a preload port, which works only while reset is held. Once reset is released, the program runs from address 0. An unused opcode stops the core and raises `halted`.

Top module: `tiny_core`

## Requirements
- R1: An instruction word is decoded as follows: bits [7:5] are the opcode, bit [4] picks the register (0 = reg0, 1 = reg1), and bits [3:0] are an address. Opcode 000 adds one to the picked register, and the result wraps modulo 256.
- R2: Opcode 001 subtracts one from the picked register, and the result wraps modulo 256 (0x00 becomes 0xFF).
- R3: Opcode 010 loads the PC with bits [3:0] when reg0 equals zero.
- R4: Opcode 010 with a nonzero reg0 changes no register, and the PC advances by one.
- R5: Opcode 100 writes the picked register into memory at bits [3:0].
- R6: Opcode 101 copies the memory word at bits [3:0] into the picked register.
- R7: Each instruction takes two cycles. The PC and the registers stay constant during the fetch cycle and change at the end of the execute cycle.
- R8: The PC is 4 bits wide, and sequential flow wraps it from 15 to 0.
- R9: Opcodes 011, 110 and 111 set `halted`. From then on the PC and both registers stay frozen until reset.
- R10: A synchronous active-high reset clears the PC, both registers and `halted`, and it leaves memory contents unchanged.
- R11: The preload port writes memory only while `rst` is high. When `rst` is low, `load_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Preload write enable, honoured only in reset |
| load_addr | input | 4 | Preload word address |
| load_data | input | 8 | Preload word |
| pc | output | 4 | Program counter |
| reg0 | output | 8 | General register 0 |
| reg1 | output | 8 | General register 1 |
| halted | output | 1 | Core stopped on an unused opcode |

## Verification
The hardest situation to reach from the ports is a taken branch. It needs reg0 to be exactly zero, and reg0 can be shaped only by running instructions. The main program therefore drives reg0 down to zero and past it to 0xFF, then back up to zero through wrap-around. This puts both the not-taken and the taken branch in one run. A skipped halt word is placed on the fall-through path, so a wrong branch decision shows up as a halt. Writes to memory are observed by loading the stored value back into the other register. The PC wrap test tries a halt word through the preload port while the program is running, to show that the port is ignored outside reset.

// File: rtl/tiny_core.sv
module tiny_core #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] reg0,
  output logic [DW-1:0] reg1,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_INC = 3'b000;
  localparam logic [2:0] OP_DEC = 3'b001;
  localparam logic [2:0] OP_BRZ = 3'b010;
  localparam logic [2:0] OP_STR = 3'b100;
  localparam logic [2:0] OP_LDR = 3'b101;
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [AW-1:0] PC_ONE = AW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ir;
  logic          exec_ph;

  wire [2:0]    opc  = ir[DW-1 -: 3];
  wire          sel  = ir[AW];
  wire [AW-1:0] addr = ir[AW-1:0];

  wire           illegal = (opc == 3'b011) || (opc[2:1] == 2'b11);
  wire           run_ex  = exec_ph && !halted;
  wire [DW-1:0]  src_reg = sel ? reg1 : reg0;
  wire [DW-1:0]  opa     = opc[2] ? mem[addr] : src_reg;
  wire           wr_reg  = (opc == OP_INC) || (opc == OP_DEC) || (opc == OP_LDR);
  wire           br_take = (opc == OP_BRZ) && (reg0 == '0);

  logic [DW-1:0] alu;
  always_comb begin
    case (opc)
      OP_INC:  alu = opa + ONE;
      OP_DEC:  alu = opa - ONE;
      default: alu = opa;
    endcase
  end

  wire [AW-1:0] pc_next = br_take ? addr : pc + PC_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (load_en) mem[load_addr] <= load_data;
    end else if (run_ex && opc == OP_STR) begin
      mem[addr] <= src_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      reg0    <= '0;
      reg1    <= '0;
      halted  <= 1'b0;
      exec_ph <= 1'b0;
      ir      <= '0;
    end else if (!halted) begin
      if (!exec_ph) begin
        ir      <= mem[pc];
        exec_ph <= 1'b1;
      end else begin
        exec_ph <= 1'b0;
        if (illegal) begin
          halted <= 1'b1;
        end else begin
          pc <= pc_next;
          if (wr_reg) begin
            if (sel) reg1 <= alu;
            else     reg0 <= alu;
          end
        end
      end
    end
  end

  // R1
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    run_ex && opc == OP_INC && !sel |=> reg0 == $past(reg0) + ONE);

  // R2
  dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    run_ex && opc == OP_DEC && sel |=> reg1 == $past(reg1) - ONE);

  // R3
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    run_ex && opc == OP_BRZ && reg0 == '0 |=> pc == $past(addr));

  // R4
  branch_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    run_ex && opc == OP_BRZ && reg0 != '0 |=> pc == $past(pc) + PC_ONE && $stable(reg0) && $stable(reg1));

  // R7
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_ph |=> $stable(pc) && $stable(reg0) && $stable(reg1));

  // R8
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    run_ex && !illegal && opc != OP_BRZ |=> pc == $past(pc) + PC_ONE);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(reg0) && $stable(reg1));
endmodule

// File: tb/tiny_core_tb.sv
module tiny_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [3:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [3:0] pc;
  logic [7:0] reg0, reg1;
  logic       halted;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  tiny_core u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .pc(pc), .reg0(reg0), .reg1(reg1), .halted(halted)
  );

  localparam logic [7:0] PROG [16] = '{
    8'h00, 8'h10, 8'h20, 8'h20, 8'h8E, 8'hBE, 8'h49, 8'h00,
    8'h4A, 8'hE0, 8'hAF, 8'h10, 8'h60, 8'h00, 8'h00, 8'h7F
  };
  // per step: {req, reg0, reg1, pc, halted}
  localparam int NSTEP = 13;
  localparam logic [24:0] STEPS [NSTEP] = '{
    {4'd1,  8'h01, 8'h00, 4'd1,  1'b0},
    {4'd1,  8'h01, 8'h01, 4'd2,  1'b0},
    {4'd2,  8'h00, 8'h01, 4'd3,  1'b0},
    {4'd2,  8'hFF, 8'h01, 4'd4,  1'b0},
    {4'd5,  8'hFF, 8'h01, 4'd5,  1'b0},
    {4'd6,  8'hFF, 8'hFF, 4'd6,  1'b0},
    {4'd4,  8'hFF, 8'hFF, 4'd7,  1'b0},
    {4'd1,  8'h00, 8'hFF, 4'd8,  1'b0},
    {4'd3,  8'h00, 8'hFF, 4'd10, 1'b0},
    {4'd6,  8'h7F, 8'hFF, 4'd11, 1'b0},
    {4'd1,  8'h7F, 8'h00, 4'd12, 1'b0},
    {4'd9,  8'h7F, 8'h00, 4'd12, 1'b1},
    {4'd9,  8'h7F, 8'h00, 4'd12, 1'b1}
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [7:0] e0, input logic [7:0] e1,
                             input logic [3:0] ep, input logic eh);
    check({req, " reg0"}, reg0, e0);
    check({req, " reg1"}, reg1, e1);
    check({req, " pc"}, pc, ep);
    check({req, " halted"}, halted, eh);
  endtask

  task automatic preload(input int addr, input logic [7:0] data);
    @(negedge clk);
    rst = 1'b1; load_en = 1'b1; load_addr = 4'(addr); load_data = data;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic step();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) preload(i, PROG[i]);
    // R10: reset state
    check_state("R10 reset", 8'h00, 8'h00, 4'd0, 1'b0);
    @(negedge clk); rst = 1'b0;
    // R7: after the fetch edge nothing architectural has moved
    @(posedge clk); @(negedge clk);
    check_state("R7 fetch", 8'h00, 8'h00, 4'd0, 1'b0);
    @(posedge clk); @(negedge clk);
    check_state("R7 exec R1", 8'h01, 8'h00, 4'd1, 1'b0);
    for (int s = 1; s < NSTEP; s++) begin
      step();
      check_state($sformatf("R%0d step %0d", STEPS[s][24:21], s),
                  STEPS[s][20:13], STEPS[s][12:5], STEPS[s][4:1], STEPS[s][0]);
    end

    // R10: reset clears registers but keeps memory (program reruns)
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check_state("R10 reset after halt", 8'h00, 8'h00, 4'd0, 1'b0);
    rst = 1'b0;
    step();
    check_state("R10 memory kept", 8'h01, 8'h00, 4'd1, 1'b0);

    // R8 / R11: all INC reg0, wrap PC; preload attempt while running
    for (int i = 0; i < 16; i++) preload(i, 8'h00);
    @(negedge clk); rst = 1'b0;
    step(); step();
    load_en = 1'b1; load_addr = 4'd5; load_data = 8'h60;
    @(negedge clk); load_en = 1'b0;
    @(posedge clk); @(negedge clk);
    for (int s = 3; s < 16; s++) step();
    check_state("R8 R11 wrap", 8'h10, 8'h00, 4'd0, 1'b0);
    step();
    check_state("R8 after wrap", 8'h11, 8'h00, 4'd1, 1'b0);

    // R9: opcode 110 and 111 halt
    preload(0, 8'hC0);
    @(negedge clk); rst = 1'b0;
    step();
    check_state("R9 op110", 8'h00, 8'h00, 4'd0, 1'b1);
    step(); step();
    check_state("R9 op110 frozen", 8'h00, 8'h00, 4'd0, 1'b1);
    preload(0, 8'h00);
    preload(1, 8'hE5);
    @(negedge clk); rst = 1'b0;
    step(); step();
    check_state("R9 op111", 8'h01, 8'h00, 4'd1, 1'b1);

    // R5 / R6 / R2: store reg1 then load into reg0, DEC reg1 wraps
    preload(0, 8'h30);   // DEC reg1 -> FF
    preload(1, 8'h9C);   // STR reg1,[12]
    preload(2, 8'hAC);   // LDR reg0,[12]
    preload(3, 8'h60);
    @(negedge clk); rst = 1'b0;
    step();
    check_state("R2 dec reg1 wrap", 8'h00, 8'hFF, 4'd1, 1'b0);
    step(); step();
    check_state("R5 R6 store-load", 8'hFF, 8'hFF, 4'd3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule